// File: doc/BRIEF.md
# Tiled Texture Quad Fetch Unit

This unit gathers the four texels that a bilinear filter needs around one integer sample point. The texture lives in memory as aligned 4x4 pixel tiles. Each tile fills exactly one cache line of sixteen 32-bit pixels, and the pixels inside a tile follow a Z-order curve. A request carries the texture base address, the width and height in pixels, the row pitch counted in tiles, and the (x, y) coordinate of the top-left texel of the quad.

The unit clamps the quad to the texture. It works out which tiles the quad touches and reads each distinct tile once through a read-only cache port with a request/response handshake. It picks each texel out of the returned lines and raises a one-cycle done strobe once the last line has arrived. The four texels stay on the outputs until the next request is accepted. A quad that sits inside one tile costs one line read. A quad that crosses a vertical or a horizontal tile edge costs two. A quad at a tile corner costs four.

Top module: `tqf_quad_fetch`

## Requirements
- R1: The right column is x+1 and the bottom row is y+1. Any column at or beyond width is replaced by width-1, and any row at or beyond height is replaced by height-1, so no line read lies outside the texture.
- R2: A texel at (cx, cy) is found in its tile line at pixel index {cy[1], cx[1], cy[0], cx[0]}. Pixel k occupies line bits [32k+31 : 32k].
- R3: The line address of the tile holding (cx, cy) is base + ((cy>>2)*pitch + (cx>>2)) * 64.
- R4: A request issues exactly one line read per distinct tile: 1, 2 or 4 reads.
- R5: The reads go out in corner order: top-left tile, then top-right, then bottom-left, then bottom-right, skipping any tile already read.
- R6: At most one line read is outstanding. A read held by a low mem_req_ready keeps its address stable until it is accepted.
- R7: done is a one-cycle pulse. It is raised only after every needed line has returned, and the texel outputs hold their values until the next returned line.
- R8: req_ready is high exactly when the unit is idle, and a request is taken on req_valid and req_ready. After reset, req_ready is 1 while done and mem_req_valid are 0.
- R9: texel_tl, texel_tr, texel_bl and texel_br carry the pixels at (x0,y0), (x1,y0), (x0,y1) and (x1,y1), where x0, x1, y0 and y1 are the clamped columns and rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Quad request present |
| req_ready | output | 1 | Unit idle, request taken |
| req_base | input | ADDR_W | Texture base byte address, 64-byte aligned |
| req_width | input | COORD_W | Texture width in pixels, at least 1 |
| req_height | input | COORD_W | Texture height in pixels, at least 1 |
| req_pitch | input | COORD_W | Row pitch in tiles |
| req_x | input | COORD_W | Quad left column |
| req_y | input | COORD_W | Quad top row |
| mem_req_valid | output | 1 | Line read request |
| mem_req_ready | input | 1 | Cache accepts the read |
| mem_req_addr | output | ADDR_W | Line byte address |
| mem_rsp_valid | input | 1 | Line data returned |
| mem_rsp_line | input | 16*PIX_W | Full tile line |
| done | output | 1 | Quad complete, one-cycle pulse |
| texel_tl | output | PIX_W | Top-left texel |
| texel_tr | output | PIX_W | Top-right texel |
| texel_bl | output | PIX_W | Bottom-left texel |
| texel_br | output | PIX_W | Bottom-right texel |

## Verification
A wrong latched tile address or a wrong split flag shows up at mem_req_addr on the very next read, or as a read count other than the expected one when done rises. A wrong slot owner or a wrong Z-order index stays hidden until done. At that point one texel shows a pixel of the wrong index or from the wrong tile. The bench fills every line so that each pixel encodes both its tile address and its index, so either fault names itself. A slot sequencer that stops early raises done before the last read. One that runs on issues an extra read, which the address log catches within the same request.

// File: rtl/tqf_pkg.sv
package tqf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } tqf_state_e;

    // Z-order position of a texel inside its 4x4 tile
    function automatic logic [3:0] z_index(input logic [1:0] xl, input logic [1:0] yl);
        return {yl[1], xl[1], yl[0], xl[0]};
    endfunction

    // Next needed slot above cur: {found, slot}
    function automatic logic [2:0] next_slot(input logic [3:0] need, input logic [1:0] cur);
        logic [2:0] r;
        r = 3'b000;
        for (int j = 3; j >= 0; j--) begin
            if ((j > int'(cur)) && need[j]) begin
                r = {1'b1, 2'(j)};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tqf_clamp.sv
module tqf_clamp #(
    parameter int COORD_W = 12
) (
    input  logic [COORD_W-1:0] coord,
    input  logic [COORD_W-1:0] limit,
    output logic [COORD_W-1:0] c_lo,
    output logic [COORD_W-1:0] c_hi
);
    logic [COORD_W:0] last_v;
    logic [COORD_W:0] next_v;

    always_comb begin
        last_v = {1'b0, limit} - 1'b1;
        next_v = {1'b0, coord} + 1'b1;
        c_lo   = ({1'b0, coord} > last_v) ? last_v[COORD_W-1:0] : coord;
        c_hi   = (next_v > last_v) ? last_v[COORD_W-1:0] : next_v[COORD_W-1:0];
    end
endmodule

// File: rtl/tqf_tile_addr.sv
module tqf_tile_addr #(
    parameter int ADDR_W     = 32,
    parameter int COORD_W    = 12,
    parameter int TILE_SHIFT = 6
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [COORD_W-1:0] pitch,
    input  logic [COORD_W-3:0] tile_col,
    input  logic [COORD_W-3:0] tile_row,
    output logic [ADDR_W-1:0]  line_addr
);
    logic [ADDR_W-1:0] tile_num;

    always_comb begin
        tile_num  = ADDR_W'(tile_row) * ADDR_W'(pitch) + ADDR_W'(tile_col);
        line_addr = base + (tile_num << TILE_SHIFT);
    end
endmodule

// File: rtl/tqf_lane_pick.sv
module tqf_lane_pick #(
    parameter int PIX_W = 32
) (
    input  logic [16*PIX_W-1:0] line,
    input  logic [3:0]          idx,
    output logic [PIX_W-1:0]    pixel
);
    always_comb begin
        pixel = line[idx*PIX_W +: PIX_W];
    end
endmodule

// File: rtl/tqf_quad_fetch.sv
module tqf_quad_fetch
    import tqf_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int COORD_W = 12,
    parameter int PIX_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [COORD_W-1:0]   req_width,
    input  logic [COORD_W-1:0]   req_height,
    input  logic [COORD_W-1:0]   req_pitch,
    input  logic [COORD_W-1:0]   req_x,
    input  logic [COORD_W-1:0]   req_y,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDR_W-1:0]    mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [16*PIX_W-1:0]  mem_rsp_line,
    output logic                 done,
    output logic [PIX_W-1:0]     texel_tl,
    output logic [PIX_W-1:0]     texel_tr,
    output logic [PIX_W-1:0]     texel_bl,
    output logic [PIX_W-1:0]     texel_br
);
    localparam int TILE_PIX   = 16;
    localparam int TILE_BYTES = TILE_PIX * PIX_W / 8;
    localparam int TILE_SHIFT = $clog2(TILE_BYTES);
    localparam int TC_W       = COORD_W - 2;
    localparam int CORNERS    = 4;

    typedef struct packed {
        tqf_state_e                        st;
        logic [1:0]                        slot;
        logic [CORNERS-1:0]                need;
        logic [CORNERS-1:0][ADDR_W-1:0]    addr;
        logic [CORNERS-1:0][3:0]           idx;
        logic [CORNERS-1:0][1:0]           owner;
        logic [CORNERS-1:0][PIX_W-1:0]     texel;
        logic                              done;
    } state_t;

    state_t s_d, s_q;

    // ---- coordinate clamping (R1) ----
    logic [COORD_W-1:0] x0, x1, y0, y1;

    tqf_clamp #(.COORD_W(COORD_W)) u_clamp_x (
        .coord(req_x), .limit(req_width), .c_lo(x0), .c_hi(x1)
    );
    tqf_clamp #(.COORD_W(COORD_W)) u_clamp_y (
        .coord(req_y), .limit(req_height), .c_lo(y0), .c_hi(y1)
    );

    logic [TC_W-1:0] tcol0, tcol1, trow0, trow1;
    logic            split_x, split_y;

    always_comb begin
        tcol0   = x0[COORD_W-1:2];
        tcol1   = x1[COORD_W-1:2];
        trow0   = y0[COORD_W-1:2];
        trow1   = y1[COORD_W-1:2];
        split_x = (tcol0 != tcol1);
        split_y = (trow0 != trow1);
    end

    // ---- per-corner tile address and in-tile index (R2, R3) ----
    logic [CORNERS-1:0][ADDR_W-1:0] corner_addr;
    logic [CORNERS-1:0][3:0]        corner_idx;
    logic [CORNERS-1:0][PIX_W-1:0]  picked;

    for (genvar k = 0; k < CORNERS; k++) begin : g_corner
        localparam bit RIGHT = (k % 2) == 1;
        localparam bit LOWER = k >= 2;

        logic [TC_W-1:0]    tc;
        logic [TC_W-1:0]    tr;
        logic [COORD_W-1:0] cx;
        logic [COORD_W-1:0] cy;

        always_comb begin
            tc = RIGHT ? tcol1 : tcol0;
            tr = LOWER ? trow1 : trow0;
            cx = RIGHT ? x1 : x0;
            cy = LOWER ? y1 : y0;
            corner_idx[k] = z_index(cx[1:0], cy[1:0]);
        end

        tqf_tile_addr #(
            .ADDR_W(ADDR_W), .COORD_W(COORD_W), .TILE_SHIFT(TILE_SHIFT)
        ) u_addr (
            .base(req_base), .pitch(req_pitch),
            .tile_col(tc), .tile_row(tr),
            .line_addr(corner_addr[k])
        );

        tqf_lane_pick #(.PIX_W(PIX_W)) u_pick (
            .line(mem_rsp_line), .idx(s_q.idx[k]), .pixel(picked[k])
        );
    end

    // ---- next-state logic ----
    logic [2:0] nxt;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        nxt      = next_slot(s_q.need, s_q.slot);

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_ISSUE;
                    s_d.slot  = 2'd0;
                    s_d.need  = {split_x & split_y, split_y, split_x, 1'b1};
                    s_d.addr  = corner_addr;
                    s_d.idx   = corner_idx;
                    // slot that supplies each corner after tile merging
                    s_d.owner[0] = 2'b00;
                    s_d.owner[1] = {1'b0, split_x};
                    s_d.owner[2] = {split_y, 1'b0};
                    s_d.owner[3] = {split_y, split_x};
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    for (int t = 0; t < CORNERS; t++) begin
                        if (s_q.owner[t] == s_q.slot) begin
                            s_d.texel[t] = picked[t];
                        end
                    end
                    if (nxt[2]) begin
                        s_d.slot = nxt[1:0];
                        s_d.st   = ST_ISSUE;
                    end else begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // ---- outputs ----
    always_comb begin
        req_ready     = (s_q.st == ST_IDLE);
        mem_req_valid = (s_q.st == ST_ISSUE);
        mem_req_addr  = s_q.addr[s_q.slot];
        done          = s_q.done;
        texel_tl      = s_q.texel[0];
        texel_tr      = s_q.texel[1];
        texel_bl      = s_q.texel[2];
        texel_br      = s_q.texel[3];
    end

endmodule

// File: rtl/tqf_quad_fetch_chk.sv
module tqf_quad_fetch_chk #(
    parameter int ADDR_W = 32,
    parameter int PIX_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic [PIX_W-1:0]  texel_tl,
    input logic [PIX_W-1:0]  texel_tr,
    input logic [PIX_W-1:0]  texel_bl,
    input logic [PIX_W-1:0]  texel_br
);
    logic [2:0] reads_q;
    logic [1:0] outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reads_q <= '0;
            outst_q <= '0;
        end else begin
            if (req_valid && req_ready) begin
                reads_q <= '0;
            end else if (mem_req_valid && mem_req_ready) begin
                reads_q <= reads_q + 1'b1;
            end
            if (mem_req_valid && mem_req_ready && !mem_rsp_valid) begin
                outst_q <= outst_q + 1'b1;
            end else if (mem_rsp_valid && !(mem_req_valid && mem_req_ready)) begin
                outst_q <= outst_q - 1'b1;
            end
        end
    end

    // R4: read count per quad is 1, 2 or 4
    a_r4_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (reads_q == 3'd1 || reads_q == 3'd2 || reads_q == 3'd4));

    // R6: no new read while one is outstanding
    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (outst_q == 2'd0));

    // R6: stalled read holds its address
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done only once all reads have returned
    a_r7_done_after_lines: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (outst_q == 2'd0 && !mem_req_valid));

    // R7: texels change only on a returned line
    a_r7_texel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rsp_valid |=> ($stable(texel_tl) && $stable(texel_tr)
                            && $stable(texel_bl) && $stable(texel_br)));

    // R8: idle and issuing are exclusive
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

endmodule

bind tqf_quad_fetch tqf_quad_fetch_chk #(
    .ADDR_W(ADDR_W),
    .PIX_W (PIX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .done         (done),
    .texel_tl     (texel_tl),
    .texel_tr     (texel_tr),
    .texel_bl     (texel_bl),
    .texel_br     (texel_br)
);

// File: tb/tqf_quad_fetch_tb.sv
`timescale 1ns/1ps
module tqf_quad_fetch_tb;
    localparam int AW = 32;
    localparam int CW = 12;
    localparam int PW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [CW-1:0] req_width = '0, req_height = '0, req_pitch = '0, req_x = '0, req_y = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [16*PW-1:0] mem_rsp_line = '0;
    logic          done;
    logic [PW-1:0] texel_tl, texel_tr, texel_bl, texel_br;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [AW-1:0] log_addr [0:7];
    int            log_n = 0;
    int            mst = 0;
    int            mcnt = 0;
    logic [AW-1:0] maddr = '0;

    always #2.5 clk = ~clk;

    tqf_quad_fetch #(.ADDR_W(AW), .COORD_W(CW), .PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_width(req_width), .req_height(req_height),
        .req_pitch(req_pitch), .req_x(req_x), .req_y(req_y),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
        .done(done),
        .texel_tl(texel_tl), .texel_tr(texel_tr), .texel_bl(texel_bl), .texel_br(texel_br)
    );

    function automatic logic [PW-1:0] pix(input logic [AW-1:0] a, input int i);
        logic [3:0] i4;
        i4 = 4'(i);
        return {i4, 4'hC, a[23:0]};
    endfunction

    function automatic logic [16*PW-1:0] make_line(input logic [AW-1:0] a);
        logic [16*PW-1:0] l;
        l = '0;
        for (int k = 0; k < 16; k++) l[k*PW +: PW] = pix(a, k);
        return l;
    endfunction

    function automatic int clampc(input int c, input int lim);
        return (c >= lim) ? lim - 1 : c;
    endfunction

    function automatic logic [AW-1:0] tile_addr(input logic [AW-1:0] b, input int p,
                                                input int cx, input int cy);
        return b + AW'(((cy / 4) * p + (cx / 4)) * 64);
    endfunction

    function automatic int zidx(input int cx, input int cy);
        return ((cy >> 1) & 1) * 8 + ((cx >> 1) & 1) * 4 + (cy & 1) * 2 + (cx & 1);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [AW-1:0] got,
                         input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // cache model: random accept stall and response delay
    always @(negedge clk) begin
        if (!rst_n) begin
            mst = 0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
        end else begin
            case (mst)
                0: begin
                    mem_rsp_valid = 1'b0;
                    mem_req_ready = ($urandom % 3) != 0;
                    if (mem_req_valid && mem_req_ready) begin
                        maddr = mem_req_addr;
                        if (log_n < 8) log_addr[log_n] = mem_req_addr;
                        log_n++;
                        mcnt = $urandom % 3;
                        mst = 1;
                    end
                end
                1: begin
                    mem_req_ready = 1'b0;
                    if (mcnt == 0) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_line  = make_line(maddr);
                        mst = 2;
                    end else begin
                        mcnt--;
                    end
                end
                default: begin
                    mem_rsp_valid = 1'b0;
                    mem_rsp_line  = '0;
                    mst = 0;
                end
            endcase
        end
    end

    task automatic run_quad(input logic [AW-1:0] b, input int w, input int h,
                            input int p, input int x, input int y);
        int x0, x1, y0, y1, n, wait_c;
        bit sx, sy;
        logic [AW-1:0] ea [0:3];
        logic [PW-1:0] et [0:3];
        x0 = clampc(x, w); x1 = clampc(x + 1, w);
        y0 = clampc(y, h); y1 = clampc(y + 1, h);
        sx = (x0 / 4) != (x1 / 4);
        sy = (y0 / 4) != (y1 / 4);
        n = 0;
        ea[n++] = tile_addr(b, p, x0, y0);
        if (sx) ea[n++] = tile_addr(b, p, x1, y0);
        if (sy) ea[n++] = tile_addr(b, p, x0, y1);
        if (sx && sy) ea[n++] = tile_addr(b, p, x1, y1);
        et[0] = pix(tile_addr(b, p, x0, y0), zidx(x0, y0));
        et[1] = pix(tile_addr(b, p, x1, y0), zidx(x1, y0));
        et[2] = pix(tile_addr(b, p, x0, y1), zidx(x0, y1));
        et[3] = pix(tile_addr(b, p, x1, y1), zidx(x1, y1));

        @(negedge clk);
        check(req_ready === 1'b1, "R8 idle ready", AW'(req_ready), 1);
        log_n = 0;
        req_base = b; req_width = CW'(w); req_height = CW'(h);
        req_pitch = CW'(p); req_x = CW'(x); req_y = CW'(y);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R8 busy after accept", AW'(req_ready), 0);
        wait_c = 0;
        while (done !== 1'b1 && wait_c < 200) begin
            @(negedge clk);
            wait_c++;
        end
        check(done === 1'b1, "R7 done seen", AW'(done), 1);
        check(log_n == n, "R4 line read count", AW'(log_n), AW'(n));
        for (int k = 0; k < 4; k++) begin
            if (k < n && k < log_n)
                check(log_addr[k] === ea[k], "R5/R3/R1 read address in order", log_addr[k], ea[k]);
        end
        check(texel_tl === et[0], "R9/R2 texel_tl", texel_tl, et[0]);
        check(texel_tr === et[1], "R9/R2 texel_tr", texel_tr, et[1]);
        check(texel_bl === et[2], "R9/R2 texel_bl", texel_bl, et[2]);
        check(texel_br === et[3], "R9/R2 texel_br", texel_br, et[3]);
        @(negedge clk);
        check(done === 1'b0, "R7 done single pulse", AW'(done), 0);
        @(negedge clk);
        check(texel_tl === et[0] && texel_br === et[3], "R7 texels held", texel_br, et[3]);
        check(mem_req_valid === 1'b0, "R6 no read after done", AW'(mem_req_valid), 0);
    endtask

    initial begin
        int w, h, p;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R8 reset ready", AW'(req_ready), 1);
        check(done === 1'b0, "R8 reset done", AW'(done), 0);
        check(mem_req_valid === 1'b0, "R8 reset mem_req_valid", AW'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req_valid === 1'b0, "R8 idle after reset",
              AW'(mem_req_valid), 0);

        // directed corners
        run_quad(32'h0001_0000, 16, 16, 4, 5, 5);     // R4 single tile
        run_quad(32'h0001_0000, 16, 16, 4, 3, 1);     // R5 horizontal split
        run_quad(32'h0001_0000, 16, 16, 4, 1, 3);     // R5 vertical split
        run_quad(32'h0001_0000, 16, 16, 4, 7, 11);    // R4 four tiles
        run_quad(32'h0002_0000, 10, 9, 3, 20, 30);    // R1 clamp both beyond
        run_quad(32'h0002_0000, 8, 8, 2, 7, 7);       // R1 clamp at last texel
        run_quad(32'h0002_0000, 8, 12, 5, 7, 3);      // R1 right clamp, vertical split
        run_quad(32'h0003_0000, 1, 1, 1, 0, 0);       // R1 one-pixel texture
        run_quad(32'h0003_0040, 40, 40, 12, 15, 15);  // R3 pitch wider than width

        // constrained random
        for (int i = 0; i < 60; i++) begin
            w = 1 + int'($urandom % 200);
            h = 1 + int'($urandom % 200);
            p = (w + 3) / 4 + int'($urandom % 4);
            run_quad({$urandom % 32'h0010_0000, 6'b0}, w, h, p,
                     int'($urandom % (w + 6)), int'($urandom % (h + 6)));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule